// File: doc/BRIEF.md
# Interleaved Cache Line Fill Controller

This block serves cache misses by fetching a whole line of four 32-bit words from a main memory built as four banks. The banks are interleaved on the low word-address bits, so consecutive words of one line sit in different banks. A fill request carries a byte address. Its line address (every bit above the line offset) is captured once and driven to all banks together. The block then waits out the single shared array access and streams the four words to the cache, one per clock. Each word carries a valid strobe and its word index, and a done pulse marks the last beat.

The banks are behavioural models built into the design. Each one has a fixed access latency and returns a computed data pattern in place of stored contents. An elaboration parameter swaps in a one-word-wide organisation. That variant fetches the words one after another with an auto-incremented address and pays the full address-plus-access cost for each word, so the cycle costs of the two organisations can be compared on the same ports.

Top module: `lfc_top`

## Requirements
- R1: While reset is held and in the first cycle after release, `busy`, `word_valid` and `fill_done` are low and `word_data` is zero.
- R2: The memory word at word address `wa`, meaning the byte address shifted right by two and zero-extended to 32 bits, holds `(wa * 32'h9E3779B9) ^ 32'h12345678` computed modulo 2^32. Word k of a fill has word address `{addr[31:4], k[1:0]}`.
- R3: In interleaved mode, a request sampled at clock edge E is accepted. Cycle 1 after E sends the address. Cycles 2 to 16 are the common 15-cycle bank access. Word k is valid in cycle 17+k, so the fill takes 20 cycles.
- R4: Words are returned in bank order 0, 1, 2, 3, and `word_idx` equals k on beat k, whatever the values of address bits 3:0.
- R5: With the one-word-wide parameter set, word k is valid in cycle 17*(k+1) after acceptance, so the fill takes 68 cycles.
- R6: `busy` is high from cycle 1 through the last beat of a fill. A request made while `busy` is high is ignored, and the fill keeps the address captured at acceptance even if `fill_addr` changes later.
- R7: `fill_done` is high for exactly one cycle, the cycle of word 3, and `busy` is low in the next cycle.
- R8: `word_valid` is low in every cycle that is not a word beat of an accepted fill, and `word_data` is zero whenever `word_valid` is low.
- R9: A request held high across the last beat is not taken in that cycle. It is accepted in the first idle cycle that follows, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_req | input | 1 | Line-fill request, sampled when idle |
| fill_addr | input | 32 | Byte address of the miss; bits 3:0 are ignored |
| busy | output | 1 | A fill is in progress |
| word_valid | output | 1 | `word_data` carries a line word this cycle |
| word_idx | output | 2 | Index of the word within the line |
| word_data | output | 32 | Returned word, zero when not valid |
| fill_done | output | 1 | One-cycle pulse with the last word |

## Verification
The delicate cycle is the last beat of a fill. In that cycle the fourth word, the done pulse and the final high cycle of `busy` all coincide with a request that may already be arriving for the next line. The bench holds a request across the last beat and the cycle after it. It then expects the request to be refused in the beat cycle, and the new fill's first word to appear exactly 17 cycles after the following edge. Throughout every fill, extra requests carrying a different address are injected. The returned data is then compared with the pattern of the originally captured line.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_FETCH = 2'd2
   } lfc_state_e;

   // data pattern produced by the behavioural banks
   localparam logic [63:0] PAT_MULT = 64'h0000_0000_9E37_79B9;
   localparam logic [63:0] PAT_SALT = 64'h0000_0000_1234_5678;

endpackage

// File: rtl/lfc_bank.sv
module lfc_bank #(
   parameter int WA_W       = 30,
   parameter int DATA_W     = 32,
   parameter int ACCESS_CYC = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WA_W-1:0]   wa_i,
   output logic              rdy_o,
   output logic [DATA_W-1:0] data_o
);
   import lfc_pkg::*;

   localparam int CNT_W = $clog2(ACCESS_CYC + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [WA_W-1:0]   wa_q;
   logic              rdy_q;
   logic [DATA_W-1:0] wa_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         wa_q  <= '0;
         rdy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(ACCESS_CYC);
         wa_q  <= wa_i;
         rdy_q <= 1'b0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
      end
   end

   assign wa_ext = DATA_W'(wa_q);
   assign rdy_o  = rdy_q;
   assign data_o = rdy_q ? ((wa_ext * DATA_W'(PAT_MULT)) ^ DATA_W'(PAT_SALT)) : '0;

   // R3: a fresh access hides the previous word until its latency elapses
   a_r3_rdy_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !rdy_o);

   // R3: the sequencer never restarts a bank mid-access
   a_r3_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (cnt_q == '0));

endmodule

// File: rtl/lfc_seq.sv
module lfc_seq #(
   parameter int ROW_W       = 28,
   parameter int IDX_W       = 2,
   parameter int LINE_WORDS  = 4,
   parameter bit INTERLEAVED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             sel_rdy_i,
   output logic             busy_o,
   output logic             start_o,
   output logic [ROW_W-1:0] row_o,
   output logic [IDX_W-1:0] beat_o,
   output logic             valid_o,
   output logic             done_o
);
   import lfc_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_WORDS - 1);

   lfc_state_e       state_q;
   logic [ROW_W-1:0] row_q;
   logic [IDX_W-1:0] beat_q;
   logic             last_beat;

   assign last_beat = (beat_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         beat_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_i) begin
               row_q   <= row_i;
               beat_q  <= '0;
               state_q <= ST_ADDR;
            end
            ST_ADDR: state_q <= ST_FETCH;
            ST_FETCH: if (sel_rdy_i) begin
               if (last_beat) begin
                  state_q <= ST_IDLE;
               end else begin
                  beat_q  <= beat_q + 1'b1;
                  state_q <= INTERLEAVED ? ST_FETCH : ST_ADDR;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (state_q != ST_IDLE);
   assign start_o = (state_q == ST_ADDR);
   assign row_o   = row_q;
   assign beat_o  = beat_q;
   assign valid_o = (state_q == ST_FETCH) && sel_rdy_i;
   assign done_o  = valid_o && last_beat;

   // R6: the captured line address is frozen for the whole fill
   a_r6_row_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(row_q));

   // R7: the done pulse is the final cycle of busy
   a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R4: each non-final beat advances the word index by one
   a_r4_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !done_o) |=> (beat_o == $past(beat_o) + 1'b1));

endmodule

// File: rtl/lfc_top.sv
module lfc_top #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int LINE_WORDS  = 4,
   parameter int ACCESS_CYC  = 15,
   parameter bit INTERLEAVED = 1'b1,
   localparam int IDX_W      = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_req,
   input  logic [ADDR_W-1:0] fill_addr,
   output logic              busy,
   output logic              word_valid,
   output logic [IDX_W-1:0]  word_idx,
   output logic [DATA_W-1:0] word_data,
   output logic              fill_done
);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int OFS_W  = IDX_W + BYTE_W;
   localparam int ROW_W  = ADDR_W - OFS_W;
   localparam int WA_W   = ROW_W + IDX_W;

   if (LINE_WORDS < 2 || (1 << IDX_W) != LINE_WORDS) begin : g_bad_words
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || DATA_W > 64 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes up to 64 bits");
   end
   if (ACCESS_CYC < 1) begin : g_bad_access
      $error("ACCESS_CYC must be at least 1");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [ROW_W-1:0]  row_q;
   logic [IDX_W-1:0]  beat;
   logic              bank_start;
   logic              sel_rdy;
   logic [DATA_W-1:0] sel_data;
   logic [OFS_W-1:0]  unused_low_bits;

   assign unused_low_bits = fill_addr[OFS_W-1:0];

   lfc_seq #(
      .ROW_W      (ROW_W),
      .IDX_W      (IDX_W),
      .LINE_WORDS (LINE_WORDS),
      .INTERLEAVED(INTERLEAVED)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (fill_req),
      .row_i    (fill_addr[ADDR_W-1:OFS_W]),
      .sel_rdy_i(sel_rdy),
      .busy_o   (busy),
      .start_o  (bank_start),
      .row_o    (row_q),
      .beat_o   (beat),
      .valid_o  (word_valid),
      .done_o   (fill_done)
   );

   if (INTERLEAVED) begin : g_interleaved
      logic [LINE_WORDS-1:0] rdy_vec;
      logic [DATA_W-1:0]     bank_data [LINE_WORDS];

      for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
         lfc_bank #(
            .WA_W      (WA_W),
            .DATA_W    (DATA_W),
            .ACCESS_CYC(ACCESS_CYC)
         ) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(bank_start),
            .wa_i   ({row_q, IDX_W'(b)}),
            .rdy_o  (rdy_vec[b]),
            .data_o (bank_data[b])
         );
      end

      assign sel_rdy  = rdy_vec[beat];
      assign sel_data = bank_data[beat];

      // R3: all banks share one access and finish in the same cycle
      a_r3_banks_in_step: assert property (@(posedge clk) disable iff (!rst_n)
         (&rdy_vec) || !(|rdy_vec));
   end else begin : g_narrow
      lfc_bank #(
         .WA_W      (WA_W),
         .DATA_W    (DATA_W),
         .ACCESS_CYC(ACCESS_CYC)
      ) bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .start_i(bank_start),
         .wa_i   ({row_q, beat}),
         .rdy_o  (sel_rdy),
         .data_o (sel_data)
      );
   end

   assign word_idx  = beat;
   assign word_data = word_valid ? sel_data : '0;

   // R6: an idle controller takes a request on the next edge
   a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !busy) |=> busy);

   // R8: beats appear only inside a fill
   a_r8_valid_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> busy);

endmodule

// File: tb/lfc_top_tb_top.sv
`timescale 1ns/1ps
module lfc_top_tb_top;

   localparam int LEN_I = 20;
   localparam int LEN_N = 68;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i_s = 1'b0;
   logic        req_n_s = 1'b0;
   logic [31:0] addr_s = '0;

   logic        busy_i, valid_i, done_i;
   logic [1:0]  idx_i;
   logic [31:0] data_i;
   logic        busy_n, valid_n, done_n;
   logic [1:0]  idx_n;
   logic [31:0] data_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit mon_en = 1'b0;

   bit          act_i = 1'b0, act_n = 1'b0;
   int          acc_i = 0, acc_n = 0;
   logic [31:0] lat_i = '0, lat_n = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lfc_top #(.INTERLEAVED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .fill_req(req_i_s), .fill_addr(addr_s),
      .busy(busy_i), .word_valid(valid_i), .word_idx(idx_i),
      .word_data(data_i), .fill_done(done_i));

   lfc_top #(.INTERLEAVED(1'b0)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .fill_req(req_n_s), .fill_addr(addr_s),
      .busy(busy_n), .word_valid(valid_n), .word_idx(idx_n),
      .word_data(data_n), .fill_done(done_n));

   function automatic logic [31:0] pat(input logic [31:0] a, input int k);
      logic [31:0] wa;
      wa = {2'b00, a[31:4], 2'(k)};
      return (wa * 32'h9E3779B9) ^ 32'h12345678;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   task automatic check_one(input bit narrow, input int n, input logic busy,
                            input logic valid, input logic [1:0] idx,
                            input logic [31:0] data, input logic done,
                            input logic [31:0] la);
      int  len;
      bit  e_valid;
      int  e_idx;
      len = narrow ? LEN_N : LEN_I;
      if (narrow) begin
         e_valid = (n >= 17) && (n <= LEN_N) && (n % 17 == 0);
         e_idx   = n / 17 - 1;
      end else begin
         e_valid = (n >= 17) && (n <= LEN_I);
         e_idx   = n - 17;
      end
      chk(busy == (n >= 1 && n <= len), "R6 busy window", 32'(busy),
          32'(n >= 1 && n <= len));
      chk(valid == e_valid, narrow ? "R5 narrow beat timing" : "R3 interleaved beat timing",
          32'(valid), 32'(e_valid));
      chk(done == (n == len), "R7 done pulse", 32'(done), 32'(n == len));
      if (e_valid) begin
         chk(idx == 2'(e_idx), "R4 word order", 32'(idx), 32'(e_idx));
         chk(data == pat(la, e_idx), "R2 word data", data, pat(la, e_idx));
      end else begin
         chk(data == '0, "R8 quiet data", data, '0);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && mon_en) begin
         int n_i, n_n;
         n_i = act_i ? cyc - acc_i + 1 : 0;
         if (n_i > LEN_I) begin act_i = 1'b0; n_i = 0; end
         n_n = act_n ? cyc - acc_n + 1 : 0;
         if (n_n > LEN_N) begin act_n = 1'b0; n_n = 0; end
         check_one(1'b0, n_i, busy_i, valid_i, idx_i, data_i, done_i, lat_i);
         check_one(1'b1, n_n, busy_n, valid_n, idx_n, data_n, done_n, lat_n);
         if (req_i_s && n_i == 0) begin act_i = 1'b1; acc_i = cyc + 1; lat_i = addr_s; end
         if (req_n_s && n_n == 0) begin act_n = 1'b1; acc_n = cyc + 1; lat_n = addr_s; end
      end
   end

   initial begin
      #25000;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] addrs [6];
      addrs[0] = 32'h0000_0000;
      addrs[1] = 32'h1234_567C;
      addrs[2] = 32'hFFFF_FFFF;
      addrs[3] = 32'h8000_0010;
      addrs[4] = 32'hDEAD_BEE4;
      addrs[5] = 32'h0000_0FF9;

      // R1: reset state
      repeat (3) begin
         @(negedge clk); #1;
         chk(!busy_i && !valid_i && !done_i && data_i == '0, "R1 reset interleaved",
             {busy_i, valid_i, done_i, |data_i}, '0);
         chk(!busy_n && !valid_n && !done_n && data_n == '0, "R1 reset narrow",
             {busy_n, valid_n, done_n, |data_n}, '0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!busy_i && !valid_i && !done_i, "R1 after release", 32'(busy_i), 32'd0);
      mon_en = 1'b1;

      // sweep: both organisations, stray requests with other addresses
      for (int t = 0; t < 6; t++) begin
         @(negedge clk);
         addr_s = addrs[t]; req_i_s = 1'b1; req_n_s = 1'b1;
         @(negedge clk);
         req_i_s = 1'b0; req_n_s = 1'b0;
         repeat (4) @(negedge clk);
         addr_s = ~addrs[t]; req_i_s = 1'b1; req_n_s = 1'b1;   // R6 stray request
         @(negedge clk);
         req_i_s = 1'b0; req_n_s = 1'b0;
         repeat (14) @(negedge clk);                             // cycle 20
         req_i_s = 1'b1;                                         // R6 request on last beat
         @(negedge clk);
         req_i_s = 1'b0;
         repeat (50) @(negedge clk);
      end

      // R9: request held across the last beat is taken on the first idle cycle
      @(negedge clk);
      addr_s = 32'h0ACE_0000; req_i_s = 1'b1;
      @(negedge clk);
      req_i_s = 1'b0;
      repeat (19) @(negedge clk);                                // cycle 20
      addr_s = 32'h5555_AAA0; req_i_s = 1'b1;
      @(negedge clk);                                            // cycle 21
      @(negedge clk);                                            // cycle 22
      req_i_s = 1'b0;
      repeat (16) @(negedge clk);                                // cycle 38
      #2;
      chk(valid_i && idx_i == 2'd0, "R9 back-to-back first beat", 32'(valid_i), 32'd1);
      chk(data_i == pat(32'h5555_AAA0, 0), "R9 back-to-back data", data_i,
          pat(32'h5555_AAA0, 0));
      repeat (30) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule